// File: doc/BRIEF.md
# Port Pin Observation Override Mux

This block sits between the ordinary GPIO output logic of a microcontroller and its port pins. For each pin it passes through the GPIO drive value and output enable, unless software has asked for an internal signal to appear on that pin instead. Three kinds of override are possible. Six selectors can each route one of three radio observation signals onto one of port 1 pins 0 to 5. One enable can place the slow 32 kHz clock on any port 0 pin. Another enable can place the digital regulator power status on any port 1 pin.

The power mode shapes two of these outputs. The slow-clock pin freezes at its last level while the chip is in the deepest mode. The regulator-status pin reads low in the two deepest modes. Configuration arrives through a small synchronous register write port. Every pin output is registered, so each result appears on the system clock edge that follows the inputs it depends on.

Top module: `pin_override_mux`

## Requirements
- R1: While reset is active every pin output and output enable is 0. After reset all overrides are off, so each pin drives the GPIO value and enable that were presented one system clock earlier.
- R2: Register writes happen when `wr_en` is high at a clock edge. Addresses 0 to 5 are the observation selectors for port 1 pins 0 to 5; in these, data bit 2 is the enable and bits 1:0 are the source index. Address 6 is the power-signal register: bit 7 enables the clock output, bits 6:4 pick its port 0 pin, bit 3 enables the regulator status, and bits 2:0 pick its port 1 pin. A write to address 7 changes nothing.
- R3: An enabled selector at address i drives port 1 pin i with `obs_sig[src]` for source indices 0 to 2, and with 0 for source index 3.
- R4: With the clock output enabled and the sampled mode not PM3, the chosen port 0 pin carries `slow_clk` delayed by one system clock.
- R5: The power mode used for freezing is captured only when `slow_clk` has just risen (it is high now and was low at the previous system clock edge). While the captured mode is PM3 (encoding 3), the clock pin holds its level.
- R6: With the regulator status enabled, the chosen port 1 pin outputs 1 when `pm` is PM0 or PM1 (encodings 0 and 1) and 0 when `pm` is PM2 or PM3 (encodings 2 and 3), one clock later.
- R7: On port 1 the regulator status takes precedence over an observation selector, and an observation selector takes precedence over GPIO.
- R8: Every overridden pin has its output enable forced to 1. Pins without an override keep their GPIO value and enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| gpio_p0_out | input | 8 | Normal GPIO drive for port 0 |
| gpio_p0_oe | input | 8 | Normal GPIO enable for port 0 |
| gpio_p1_out | input | 8 | Normal GPIO drive for port 1 |
| gpio_p1_oe | input | 8 | Normal GPIO enable for port 1 |
| obs_sig | input | 3 | Radio observation signals |
| slow_clk | input | 1 | 32 kHz clock, sampled as data |
| pm | input | 2 | Current power mode, 0 to 3 |
| pin_p0_out | output | 8 | Final port 0 drive |
| pin_p0_oe | output | 8 | Final port 0 output enable |
| pin_p1_out | output | 8 | Final port 1 drive |
| pin_p1_oe | output | 8 | Final port 1 output enable |

## Verification
A register write lands at the first clock edge, and the pins reflect it at the second. A change on GPIO, observation, `pm` or `slow_clk` inputs shows at the pins one edge later. The bench drives every input on the falling edge, advances one rising edge (two after a write), and samples on the next falling edge. The freeze check traces `slow_clk` edge by edge: the mode is captured on a rising edge but only affects the pin from the following edge, so the expected level is worked out for each step.

// File: rtl/pom_pkg.sv
package pom_pkg;
    typedef enum logic [1:0] {
        PM0 = 2'd0,
        PM1 = 2'd1,
        PM2 = 2'd2,
        PM3 = 2'd3
    } pmode_e;

    localparam int SRC_W = 2;

    typedef struct packed {
        logic             en;
        logic [SRC_W-1:0] src;
    } obs_sel_t;
endpackage

// File: rtl/pom_regs.sv
module pom_regs
    import pom_pkg::*;
#(
    parameter int OBS_PINS  = 6,
    parameter int PIN_IDX_W = 3,
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    output obs_sel_t [OBS_PINS-1:0]     obs_cfg,
    output logic                        clk_en,
    output logic [PIN_IDX_W-1:0]        clk_pin,
    output logic                        reg_en,
    output logic [PIN_IDX_W-1:0]        reg_pin
);
    localparam int PWR_ADDR   = OBS_PINS;
    localparam int CLK_EN_BIT = 7;
    localparam int CLK_PIN_LO = 4;
    localparam int REG_EN_BIT = 3;
    localparam int REG_PIN_LO = 0;

    typedef struct packed {
        obs_sel_t [OBS_PINS-1:0] obs;
        logic                    clk_en;
        logic [PIN_IDX_W-1:0]    clk_pin;
        logic                    reg_en;
        logic [PIN_IDX_W-1:0]    reg_pin;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            for (int i = 0; i < OBS_PINS; i++) begin
                if (int'(wr_addr) == i) begin
                    regs_d.obs[i].en  = wr_data[SRC_W];
                    regs_d.obs[i].src = wr_data[SRC_W-1:0];
                end
            end
            if (int'(wr_addr) == PWR_ADDR) begin
                regs_d.clk_en  = wr_data[CLK_EN_BIT];
                regs_d.clk_pin = wr_data[CLK_PIN_LO +: PIN_IDX_W];
                regs_d.reg_en  = wr_data[REG_EN_BIT];
                regs_d.reg_pin = wr_data[REG_PIN_LO +: PIN_IDX_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign obs_cfg = regs_q.obs;
    assign clk_en  = regs_q.clk_en;
    assign clk_pin = regs_q.clk_pin;
    assign reg_en  = regs_q.reg_en;
    assign reg_pin = regs_q.reg_pin;

    // R2
    pwr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_addr) == PWR_ADDR) |=>
            (clk_en == $past(wr_data[CLK_EN_BIT]) && reg_en == $past(wr_data[REG_EN_BIT])));

    // R2
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q));
endmodule

// File: rtl/pom_slowclk.sv
module pom_slowclk
    import pom_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slow_clk,
    input  logic [1:0] pm,
    output logic       frozen,
    output logic       lvl
);
    typedef struct packed {
        logic   sclk;
        pmode_e pm;
        logic   lvl;
    } sc_t;

    sc_t sc_d, sc_q;
    logic rise;

    assign rise   = slow_clk && !sc_q.sclk;
    assign frozen = (sc_q.pm == PM3);
    assign lvl    = frozen ? sc_q.lvl : slow_clk;

    always_comb begin
        sc_d      = sc_q;
        sc_d.sclk = slow_clk;
        if (rise) sc_d.pm = pmode_e'(pm);
        sc_d.lvl  = lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sc_q <= '{sclk: 1'b0, pm: PM0, lvl: 1'b0};
        else        sc_q <= sc_d;
    end

    // R5
    mode_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(sc_q.pm));
endmodule

// File: rtl/pin_override_mux.sv
module pin_override_mux
    import pom_pkg::*;
#(
    parameter int PORT_W   = 8,
    parameter int OBS_PINS = 6,
    parameter int OBS_SRCS = 3,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PORT_W-1:0] gpio_p0_out,
    input  logic [PORT_W-1:0] gpio_p0_oe,
    input  logic [PORT_W-1:0] gpio_p1_out,
    input  logic [PORT_W-1:0] gpio_p1_oe,
    input  logic [OBS_SRCS-1:0] obs_sig,
    input  logic              slow_clk,
    input  logic [1:0]        pm,
    output logic [PORT_W-1:0] pin_p0_out,
    output logic [PORT_W-1:0] pin_p0_oe,
    output logic [PORT_W-1:0] pin_p1_out,
    output logic [PORT_W-1:0] pin_p1_oe
);
    localparam int PIN_IDX_W = $clog2(PORT_W);
    localparam int ADDR_W    = 3;

    typedef struct packed {
        logic [PORT_W-1:0] p0_out;
        logic [PORT_W-1:0] p0_oe;
        logic [PORT_W-1:0] p1_out;
        logic [PORT_W-1:0] p1_oe;
    } pins_t;

    obs_sel_t [OBS_PINS-1:0] obs_cfg;
    logic                    clk_en, reg_en, frozen, clk_lvl, reg_up;
    logic [PIN_IDX_W-1:0]    clk_pin, reg_pin;
    pins_t                   pins_d, pins_q;

    pom_regs #(
        .OBS_PINS(OBS_PINS), .PIN_IDX_W(PIN_IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .obs_cfg(obs_cfg), .clk_en(clk_en), .clk_pin(clk_pin),
        .reg_en(reg_en), .reg_pin(reg_pin)
    );

    pom_slowclk u_slowclk (
        .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .pm(pm),
        .frozen(frozen), .lvl(clk_lvl)
    );

    assign reg_up = (pm == PM0) || (pm == PM1);

    always_comb begin
        pins_d.p0_out = gpio_p0_out;
        pins_d.p0_oe  = gpio_p0_oe;
        pins_d.p1_out = gpio_p1_out;
        pins_d.p1_oe  = gpio_p1_oe;
        if (clk_en) begin
            pins_d.p0_out[clk_pin] = clk_lvl;
            pins_d.p0_oe[clk_pin]  = 1'b1;
        end
        for (int i = 0; i < OBS_PINS; i++) begin
            if (obs_cfg[i].en) begin
                pins_d.p1_out[i] = (int'(obs_cfg[i].src) < OBS_SRCS) ? obs_sig[obs_cfg[i].src] : 1'b0;
                pins_d.p1_oe[i]  = 1'b1;
            end
        end
        if (reg_en) begin
            pins_d.p1_out[reg_pin] = reg_up;
            pins_d.p1_oe[reg_pin]  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pins_q <= '0;
        else        pins_q <= pins_d;
    end

    assign pin_p0_out = pins_q.p0_out;
    assign pin_p0_oe  = pins_q.p0_oe;
    assign pin_p1_out = pins_q.p1_out;
    assign pin_p1_oe  = pins_q.p1_oe;

    logic any_obs;
    always_comb begin
        any_obs = 1'b0;
        for (int i = 0; i < OBS_PINS; i++) any_obs = any_obs | obs_cfg[i].en;
    end

    // R1
    gpio_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_en && !any_obs) |=> (pin_p1_out == $past(gpio_p1_out) && pin_p1_oe == $past(gpio_p1_oe)));

    // R4
    clk_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !frozen) |=> (pin_p0_out[$past(clk_pin)] == $past(slow_clk) && pin_p0_oe[$past(clk_pin)]));

    // R6
    reg_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && pm[1]) |=> (!pin_p1_out[$past(reg_pin)] && pin_p1_oe[$past(reg_pin)]));

    generate
        for (genvar gi = 0; gi < OBS_PINS; gi++) begin : g_obs_chk
            // R3
            reserved_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (obs_cfg[gi].en && int'(obs_cfg[gi].src) >= OBS_SRCS && !reg_en) |=>
                    (!pin_p1_out[gi] && pin_p1_oe[gi]));
        end
    endgenerate
endmodule

// File: tb/pin_override_mux_bench.sv
module pin_override_mux_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0, rst_n = 0, wr_en = 0, slow_clk = 0;
    logic [2:0] wr_addr = 0, obs_sig = 0;
    logic [7:0] wr_data = 0, g0o = 0, g0e = 0, g1o = 0, g1e = 0;
    logic [1:0] pm = 0;
    logic [7:0] p0o, p0e, p1o, p1e;
    int n_run = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_override_mux u_pin_override_mux (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .gpio_p0_out(g0o), .gpio_p0_oe(g0e), .gpio_p1_out(g1o), .gpio_p1_oe(g1e),
        .obs_sig(obs_sig), .slow_clk(slow_clk), .pm(pm),
        .pin_p0_out(p0o), .pin_p0_oe(p0e), .pin_p1_out(p1o), .pin_p1_oe(p1e)
    );

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag, input logic [7:0] e0o, input logic [7:0] e0e,
                           input logic [7:0] e1o, input logic [7:0] e1e);
        chk({tag, " p0_out"}, p0o, e0o);
        chk({tag, " p0_oe"},  p0e, e0e);
        chk({tag, " p1_out"}, p1o, e1o);
        chk({tag, " p1_oe"},  p1e, e1e);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] e;
        @(negedge clk);
        g0o = 8'h5A; g0e = 8'hC3; g1o = 8'h96; g1e = 8'h0F;
        tick();
        chk_all("R1 in reset", 8'h00, 8'h00, 8'h00, 8'h00);
        rst_n = 1;
        tick();
        chk_all("R1 after reset", 8'h5A, 8'hC3, 8'h96, 8'h0F);

        // R3 R8: every selector, every source, every signal pattern
        for (int pin = 0; pin < 6; pin++) begin
            for (int src = 0; src < 4; src++) begin
                for (int pat = 0; pat < 8; pat++) begin
                    g1o = 8'(pin * 37 + pat * 11 + src);
                    g1e = 8'(pin * 13 + pat);
                    obs_sig = 3'(pat);
                    wr(3'(pin), 8'(4 + src));
                    tick();
                    e = g1o;
                    e[pin] = (src == 3) ? 1'b0 : obs_sig[src];
                    chk("R3 obs p1_out", p1o, e);
                    chk("R8 obs p1_oe", p1e, g1e | 8'(1 << pin));
                end
            end
            wr(3'(pin), 8'h00);
        end
        tick();
        chk("R8 obs off", p1o, g1o);

        // R4 R8: clock onto each port 0 pin
        pm = 0;
        for (int pin = 0; pin < 8; pin++) begin
            wr(3'd6, 8'h80 | 8'(pin << 4));
            for (int s = 0; s < 2; s++) begin
                g0o = 8'(pin * 29 + s); g0e = 8'(pin * 7);
                slow_clk = s[0];
                tick();
                e = g0o; e[pin] = s[0];
                chk("R4 clk p0_out", p0o, e);
                chk("R8 clk p0_oe", p0e, g0e | 8'(1 << pin));
            end
        end
        slow_clk = 0;
        wr(3'd6, 8'h00);
        tick();

        // R6: regulator status, every pin and mode
        for (int pin = 0; pin < 8; pin++) begin
            wr(3'd6, 8'h08 | 8'(pin));
            for (int m = 0; m < 4; m++) begin
                g1o = 8'(pin * 53 + m); g1e = 8'(m * 3);
                pm = 2'(m);
                tick();
                e = g1o; e[pin] = (m < 2);
                chk("R6 reg p1_out", p1o, e);
                chk("R8 reg p1_oe", p1e, g1e | 8'(1 << pin));
            end
        end
        wr(3'd6, 8'h00);

        // R7 precedence
        g1o = 8'h00; g1e = 8'h00;
        wr(3'd2, 8'h04);
        wr(3'd6, 8'h0A);
        obs_sig = 3'b001; pm = 2; tick();
        chk("R7 reg over obs low", p1o, 8'h00);
        obs_sig = 3'b000; pm = 0; tick();
        chk("R7 reg over obs high", p1o, 8'h04);
        wr(3'd6, 8'h00); tick();
        chk("R7 obs over gpio", p1o, 8'h00);
        g1o = 8'hFF; tick();
        chk("R7 obs over gpio ones", p1o, 8'hFB);
        wr(3'd2, 8'h00);

        // R2: address 7 ignored
        wr(3'd7, 8'hFF); tick();
        chk_all("R2 addr7 ignored", g0o, g0e, g1o, g1e);
        // R2: address 6 field positions
        wr(3'd6, 8'hD0); tick();
        e = g0o; e[5] = slow_clk;
        chk("R2 clk pin field", p0o, e);
        wr(3'd6, 8'h00);

        // R5 freeze sequence, clock on pin 3
        g0o = 8'h00; g0e = 8'h00; pm = 0; slow_clk = 0;
        wr(3'd6, 8'hB0); tick();
        chk("R5 start low", p0o, 8'h00);
        slow_clk = 1; tick();
        chk("R5 running high", p0o, 8'h08);
        pm = 3; slow_clk = 0; tick();
        chk("R5 low before capture", p0o, 8'h00);
        slow_clk = 1; tick();
        chk("R5 capture edge", p0o, 8'h08);
        for (int k = 0; k < 4; k++) begin
            slow_clk = ~slow_clk; tick();
            chk("R5 frozen hold", p0o, 8'h08);
        end
        pm = 0; slow_clk = 0; tick();
        chk("R5 frozen before wake", p0o, 8'h08);
        slow_clk = 1; tick();
        chk("R5 wake edge", p0o, 8'h08);
        slow_clk = 0; tick();
        chk("R5 resumed", p0o, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule